// File: doc/BRIEF.md
# Auto-Increment Colour Palette Lookup

This block is a 256-entry colour look-up table. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. Software loads the table through one write-only register port. Every bus word carries a selector in its top byte and a payload in its low 24 bits. One selector sets the table write pointer. Another stores a colour at the pointer, and the pointer then steps by one with wrap-around. A full table load is therefore one pointer write followed by a stream of colour writes.

On the display side, a pixel word and a 3-bit colour-depth code arrive every cycle. The block turns them into three table indices, one per channel, reads the three channel tables, and registers the result.
- At low depths, the three channels share one index.
- At 16 bits per pixel, each channel reads through its own overlapping byte window of the pixel.
- At 32 bits per pixel, each pixel byte indexes its own channel, so the table acts as a per-channel transfer curve.

Top module: `palette_lut`

## Requirements
- R1: While reset is held, `rgb_out` is 0. The write pointer leaves reset at 0, so the first colour write after reset lands in entry 0 even with no pointer write.
- R2: A bus word is accepted when `wr_en` is 1. Its selector is `wr_word[31:24]`: 8'h10 selects a pointer write and 8'h20 selects a colour write. A colour payload is red in bits [7:0], green in bits [15:8] and blue in bits [23:16]. `rgb_out` uses the same packing.
- R3: A pointer write loads the pointer from `wr_word[7:0]`. Payload bits [23:8] have no effect on the pointer.
- R4: A colour write stores its payload in the entry at the pointer. The pointer then increments modulo 256, so after entry 255 the next colour write goes to entry 0.
- R5: A word with any other selector, or any word presented while `wr_en` is 0, leaves both the table and the pointer unchanged.
- R6: For depth codes 0, 1, 2 and 3 (1, 2, 4 and 8 bpp), the low 1, 2, 4 or 8 pixel bits are zero-extended to 8 bits. That value indexes all three channels.
- R7: For depth code 4 (16 bpp), the channel indices are: red from pixel[7:0], green from pixel[11:4], blue from pixel[15:8].
- R8: For depth code 6 (32 bpp), the channel indices are: red from pixel[7:0], green from pixel[15:8], blue from pixel[23:16].
- R9: The unused depth codes 5 and 7 behave like code 3: pixel[7:0] indexes all channels.
- R10: A lookup appears on `rgb_out` one clock after the pixel is presented. A colour write and a lookup of the same entry in the same cycle return the entry's old value; the new value appears one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus word valid |
| wr_word | input | 32 | Selector in [31:24], payload in [23:0] |
| depth | input | 3 | Colour-depth code |
| pix | input | 24 | Pixel word |
| rgb_out | output | 24 | Registered colour: red [7:0], green [15:8], blue [23:16] |

## Verification
A write pointer that is off by one, fails to wrap, or moves on an ignored word shows up as a colour in the wrong entry. The bench reads back neighbouring entries as ordinary lookups one clock after the stimulus, so this kind of fault is exposed there. A wrong byte window at 16 or 32 bpp corrupts only the affected channel, and that channel is wrong on the very next clock after the pixel. A read path that passes write data straight through instead of using the registered table is exposed by the same-cycle write-and-lookup case: the new colour would appear one clock early.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;

  localparam int IDX_W = 8;

  localparam logic [2:0] DEP_1BPP  = 3'd0;
  localparam logic [2:0] DEP_2BPP  = 3'd1;
  localparam logic [2:0] DEP_4BPP  = 3'd2;
  localparam logic [2:0] DEP_8BPP  = 3'd3;
  localparam logic [2:0] DEP_16BPP = 3'd4;
  localparam logic [2:0] DEP_32BPP = 3'd6;

  typedef struct packed {
    logic [IDX_W-1:0] b;
    logic [IDX_W-1:0] g;
    logic [IDX_W-1:0] r;
  } chan_idx_t;

  // Per-channel table index from the depth code and the pixel word.
  function automatic chan_idx_t map_index(input logic [2:0] dep,
                                          input logic [23:0] pix);
    chan_idx_t o;
    logic [IDX_W-1:0] shared;
    shared = pix[7:0];
    case (dep)
      DEP_1BPP: shared = {7'd0, pix[0]};
      DEP_2BPP: shared = {6'd0, pix[1:0]};
      DEP_4BPP: shared = {4'd0, pix[3:0]};
      default:  shared = pix[7:0];
    endcase
    o.r = shared;
    o.g = shared;
    o.b = shared;
    if (dep == DEP_16BPP) begin
      o.r = pix[7:0];
      o.g = pix[11:4];
      o.b = pix[15:8];
    end else if (dep == DEP_32BPP) begin
      o.r = pix[7:0];
      o.g = pix[15:8];
      o.b = pix[23:16];
    end
    return o;
  endfunction

  // Next write pointer after a colour store.
  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return p + IDX_W'(1);
  endfunction

endpackage

// File: rtl/palette_wr_ctrl.sv
module palette_wr_ctrl
  import palette_lut_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SEL_W = 8,
  parameter logic [SEL_W-1:0] SEL_INDEX = 8'h10,
  parameter logic [SEL_W-1:0] SEL_DATA  = 8'h20,
  localparam int PAY_W = BUS_W - SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_word,
  output logic [IDX_W-1:0] ptr,
  output logic             data_we,
  output logic [PAY_W-1:0] payload
);

  logic [SEL_W-1:0] sel;
  logic             idx_load;

  assign sel      = wr_word[BUS_W-1 -: SEL_W];
  assign payload  = wr_word[PAY_W-1:0];
  assign idx_load = wr_en && (sel == SEL_INDEX);
  assign data_we  = wr_en && (sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (idx_load) ptr <= payload[IDX_W-1:0];
    else if (data_we)  ptr <= ptr_next(ptr);
  end

  // R3
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[BUS_W-1 -: SEL_W] == SEL_INDEX)
      |=> ptr == $past(wr_word[IDX_W-1:0]));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[BUS_W-1 -: SEL_W] == SEL_DATA)
      |=> ptr == $past(ptr) + IDX_W'(1));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_word[BUS_W-1 -: SEL_W] != SEL_DATA &&
                wr_word[BUS_W-1 -: SEL_W] != SEL_INDEX))
      |=> $stable(ptr));

endmodule

// File: rtl/palette_index_map.sv
module palette_index_map
  import palette_lut_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic [2:0]       depth,
  input  logic [PIX_W-1:0] pix,
  output chan_idx_t        idx
);

  assign idx = map_index(depth, pix);

  always_comb begin
    if (!$isunknown({depth, pix})) begin
      // R6
      if (depth <= DEP_8BPP || depth == 3'd5 || depth == 3'd7)
        same_idx_chk: assert (idx.r == idx.g && idx.g == idx.b);
      // R7
      if (depth == DEP_16BPP)
        split_overlap_chk: assert (idx.g[3:0] == idx.r[7:4] &&
                                   idx.g[7:4] == idx.b[3:0]);
    end
  end

endmodule

// File: rtl/palette_bank.sv
module palette_bank #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CH_W-1:0]  wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [CH_W-1:0]  rdata
);

  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_lut_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SEL_W = 8,
  parameter int CH_W  = 8,
  parameter int PIX_W = 24,
  parameter logic [SEL_W-1:0] SEL_INDEX = 8'h10,
  parameter logic [SEL_W-1:0] SEL_DATA  = 8'h20,
  localparam int N_CH  = 3,
  localparam int RGB_W = N_CH * CH_W,
  localparam int PAY_W = BUS_W - SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_word,
  input  logic [2:0]       depth,
  input  logic [PIX_W-1:0] pix,
  output logic [RGB_W-1:0] rgb_out
);

  logic [IDX_W-1:0] ptr;
  logic             data_we;
  logic [PAY_W-1:0] payload;
  chan_idx_t        idx;
  logic [IDX_W-1:0] ch_raddr [N_CH];

  palette_wr_ctrl #(
    .BUS_W(BUS_W), .SEL_W(SEL_W),
    .SEL_INDEX(SEL_INDEX), .SEL_DATA(SEL_DATA)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .ptr(ptr), .data_we(data_we), .payload(payload)
  );

  palette_index_map #(.PIX_W(PIX_W)) u_map (
    .depth(depth), .pix(pix), .idx(idx)
  );

  assign ch_raddr[0] = idx.r;
  assign ch_raddr[1] = idx.g;
  assign ch_raddr[2] = idx.b;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    palette_bank #(.IDX_W(IDX_W), .CH_W(CH_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(data_we), .waddr(ptr),
      .wdata(payload[c*CH_W +: CH_W]), .raddr(ch_raddr[c]),
      .rdata(rgb_out[c*CH_W +: CH_W])
    );
  end

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> rgb_out == '0);

endmodule

// File: tb/palette_lut_tb.sv
module palette_lut_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_word = '0;
  logic [2:0]  depth = 3'd3;
  logic [23:0] pix = '0;
  logic [23:0] rgb_out;

  int checks = 0;
  int fails  = 0;

  logic [23:0] exp_mem [256];
  logic [7:0]  exp_ptr = 8'd0;

  localparam logic [7:0] S_IDX = 8'h10;
  localparam logic [7:0] S_DAT = 8'h20;

  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 24'hFFFFFF}, {3'd1, 24'h000006}, {3'd2, 24'h0000AB},
    {3'd3, 24'h345678}, {3'd4, 24'h00ABCD}, {3'd4, 24'hFF00F0},
    {3'd6, 24'h112233}, {3'd6, 24'hFF0001}, {3'd5, 24'h000042},
    {3'd7, 24'hFFFF80}, {3'd0, 24'h000000}, {3'd3, 24'h0000FF}
  };

  palette_lut u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .depth(depth), .pix(pix), .rgb_out(rgb_out)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] pattern(input int i);
    logic [7:0] r, g, b;
    r = 8'(i);
    g = 8'(i) ^ 8'h5A;
    b = 8'((i * 3 + 7) % 256);
    return {b, g, r};
  endfunction

  function automatic logic [23:0] expect_rgb(input logic [2:0] d, input logic [23:0] p);
    int ir, ig, ib, v;
    v = int'(p);
    case (d)
      3'd0: begin ir = v % 2;   ig = ir; ib = ir; end
      3'd1: begin ir = v % 4;   ig = ir; ib = ir; end
      3'd2: begin ir = v % 16;  ig = ir; ib = ir; end
      3'd4: begin ir = v % 256; ig = (v / 16) % 256; ib = (v / 256) % 256; end
      3'd6: begin ir = v % 256; ig = (v / 256) % 256; ib = (v / 65536) % 256; end
      default: begin ir = v % 256; ig = ir; ib = ir; end
    endcase
    return {exp_mem[ib][23:16], exp_mem[ig][15:8], exp_mem[ir][7:0]};
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w, input logic en);
    @(negedge clk);
    wr_en = en;
    wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_word = '0;
  endtask

  task automatic wr_index(input logic [23:0] v);
    put_word({S_IDX, v}, 1'b1);
    exp_ptr = v[7:0];
  endtask

  task automatic wr_data(input logic [23:0] v);
    put_word({S_DAT, v}, 1'b1);
    exp_mem[exp_ptr] = v;
    exp_ptr = exp_ptr + 8'd1;
  endtask

  task automatic look(input logic [2:0] d, input logic [23:0] p, input string req);
    @(negedge clk);
    depth = d;
    pix = p;
    @(negedge clk);
    check(rgb_out, expect_rgb(d, p), req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(rgb_out, 24'h0, "R1 reset output");
    rst_n = 1'b1;

    // R1: pointer starts at 0
    wr_data(24'hC0FFEE);
    look(3'd3, 24'h000000, "R1 pointer reset");

    // R2 R4: full load from 0
    wr_index(24'h000000);
    for (int i = 0; i < 256; i++) wr_data(pattern(i));
    look(3'd3, 24'h0000A5, "R2 loaded entry");

    // R6 R7 R8 R9 vector table
    for (int k = 0; k < NV; k++) begin
      case (VEC[k][26:24])
        3'd4:    look(VEC[k][26:24], VEC[k][23:0], "R7 16bpp split");
        3'd6:    look(VEC[k][26:24], VEC[k][23:0], "R8 32bpp bytes");
        3'd5, 3'd7: look(VEC[k][26:24], VEC[k][23:0], "R9 spare code");
        default: look(VEC[k][26:24], VEC[k][23:0], "R6 shared index");
      endcase
    end

    // R4 wrap: pointer is back at 0
    wr_data(24'h123456);
    look(3'd3, 24'h000000, "R4 wrap entry 0");
    look(3'd3, 24'h000001, "R4 wrap entry 1 untouched");

    // R5 ignored words
    put_word({8'h30, 24'h999999}, 1'b1);
    put_word({S_DAT, 24'h888888}, 1'b0);
    put_word({S_IDX, 24'h000077}, 1'b0);
    look(3'd3, 24'h000001, "R5 entry 1 unchanged");
    wr_data(24'hABCDEF);
    look(3'd3, 24'h000001, "R5 pointer held");
    look(3'd3, 24'h000002, "R5 entry 2 untouched");

    // R3 pointer writes
    wr_index(24'hFFFF05);
    wr_data(24'h0A0B0C);
    look(3'd3, 24'h000005, "R3 upper payload ignored");
    look(3'd3, 24'h000006, "R3 next entry untouched");
    wr_index(24'h0000C8);
    wr_data(24'h0F0F0F);
    look(3'd3, 24'h0000C8, "R3 entry 200");
    look(3'd3, 24'h0000C7, "R3 entry 199 untouched");

    // R10 same-cycle write and lookup of entry 201
    @(negedge clk);
    depth = 3'd3;
    pix = 24'h0000C9;
    wr_en = 1'b1;
    wr_word = {S_DAT, 24'h777777};
    @(negedge clk);
    wr_en = 1'b0;
    wr_word = '0;
    check(rgb_out, pattern(201), "R10 old value same cycle");
    exp_mem[201] = 24'h777777;
    exp_ptr = exp_ptr + 8'd1;
    @(negedge clk);
    check(rgb_out, 24'h777777, "R10 new value next cycle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule